// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is the configuration front end of a multi-function I/O controller. A host reaches it through two byte-wide I/O locations: the lower one (address bit 0) serves both as the unlock port and as the register index, and the upper one (address bit 1) is the data window onto whichever configuration register the index points at. The interface starts out locked. The host opens it by writing the enter key 0x87 to the lower port twice in a row, and closes it again by writing the exit key 0xAA to the same port.

While the interface is open, configuration registers come in two kinds. Registers below 0x30 are global and shared by every function. These are the logical-device selector at 0x07, a read-only identification byte at 0x20, and a small window of pin-multiplexing bytes. Registers from 0x30 upward are banked, and each logical device keeps its own copy. The selector at 0x07 chooses which copy the data port reaches. Bit 0 of a device's register 0x30 is its activation bit. The block drives every banked register, every activation bit and every global pin-mux byte straight out to the functional blocks behind it.

Top module: `sio_cfg_port`

## Requirements
- R1: After synchronous reset the port is locked, every writable register, the selector and the index are 0x00, and no activation bit is set.
- R2: The port opens only once 0x87 has been written to the index port (address 0) on two consecutive index-port writes. A single 0x87 leaves it locked.
- R3: Any index-port write of a value other than 0x87 between the two key bytes restarts the sequence. The next 0x87 then counts as a first key byte.
- R4: While locked, data-port (address 1) writes change no register and data-port reads return 0xFF.
- R5: Writing 0xAA to the index port while open locks the port. The index register keeps the value it held before the exit key.
- R6: While open, an index-port read returns the current index. While locked it returns 0xFF.
- R7: Index 0x07 holds the logical-device selector, and banked indices 0x30 and up reach only the selected device's copy.
- R8: Index 0x20 reads the CHIP_ID parameter (default 0xA0), and data writes to it are ignored.
- R9: Bit 0 of register 0x30 of device d drives ldev_act_o[d].
- R10: The pin-mux bytes at GMUX_BASE (default 0x28) through GMUX_BASE+GMUX_NUM-1 are global. A value written under one selector reads back unchanged under any other.
- R11: When the selector is NUM_LDEV or larger, banked writes are ignored and banked reads return 0x00. Unimplemented indices read 0x00 and ignore writes.
- R12: io_rdata is 0x00 whenever io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 1 | 0 selects the index/key port, 1 selects the data port |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe; io_rdata is valid in the same cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| glob_mux_o | output | GMUX_NUM*8 | Global pin-mux bytes, lowest index in the low byte |
| ldev_cfg_o | output | NUM_LDEV*NUM_BANK*8 | Banked registers, device-major, lowest index in the low byte |
| ldev_act_o | output | NUM_LDEV | Activation bit of each logical device |

## Verification
The unlock logic is tested with four key patterns: one 0x87, two in a row, a pair broken by a foreign byte, and a broken pair followed by a further 0x87. Together they separate a two-write key from a one-write key and show whether the sequence resets or is merely paused. A data-port write made while locked, read back after unlocking, shows whether locked writes are really discarded. The banked/global split is tested by writing distinct values under different selectors. A bank leak shows up as a value appearing under the wrong device, and a global byte stored per device shows up as a value missing under another selector. An out-of-range selector and unimplemented indices check that stray accesses land nowhere.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_ENTER     = 8'h87;
    localparam logic [7:0] KEY_EXIT      = 8'hAA;
    localparam logic [7:0] IDX_LDSEL     = 8'h07;
    localparam logic [7:0] IDX_CHIPID    = 8'h20;
    localparam logic [7:0] IDX_BANK_BASE = 8'h30;
    localparam logic [7:0] RD_LOCKED     = 8'hFF;
    localparam logic [7:0] RD_EMPTY      = 8'h00;

    typedef struct packed {
        logic       idx_wr;
        logic       dat_wr;
        logic [7:0] data;
    } io_op_t;

    function automatic logic in_window(input logic [7:0] idx,
                                       input logic [7:0] base,
                                       input int         n);
        return (int'(idx) >= int'(base)) && (int'(idx) < int'(base) + n);
    endfunction

    function automatic int win_off(input logic [7:0] idx,
                                   input logic [7:0] base);
        return int'(idx) - int'(base);
    endfunction

endpackage

// File: rtl/sio_key_lock.sv
module sio_key_lock
    import sio_cfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  io_op_t op,
    output logic   unlocked,
    output logic   load_idx
);
    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (op.idx_wr) begin
            unique case (state_q)
                KEY_IDLE: if (op.data == KEY_ENTER) state_d = KEY_HALF;
                KEY_HALF: state_d = (op.data == KEY_ENTER) ? KEY_OPEN : KEY_IDLE;
                KEY_OPEN: if (op.data == KEY_EXIT) state_d = KEY_IDLE;
                default:  state_d = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_IDLE;
        else     state_q <= state_d;
    end

    assign unlocked = (state_q == KEY_OPEN);
    assign load_idx = op.idx_wr && unlocked && (op.data != KEY_EXIT);
endmodule

// File: rtl/sio_cfg_global.sv
module sio_cfg_global
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] GMUX_BASE = 8'h28,
    parameter int         GMUX_NUM  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [7:0]            idx,
    input  logic [7:0]            wdata,
    output logic [7:0]            ldsel,
    output logic [GMUX_NUM*8-1:0] mux_o
);
    logic [7:0] ldsel_q;

    always_ff @(posedge clk) begin
        if (rst)                             ldsel_q <= 8'h00;
        else if (wr_en && idx == IDX_LDSEL)  ldsel_q <= wdata;
    end
    assign ldsel = ldsel_q;

    for (genvar g = 0; g < GMUX_NUM; g++) begin : g_mux
        localparam logic [7:0] MY_IDX = GMUX_BASE + 8'(g);
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)                         byte_q <= 8'h00;
            else if (wr_en && idx == MY_IDX) byte_q <= wdata;
        end
        assign mux_o[g*8 +: 8] = byte_q;
    end
endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
    import sio_cfg_pkg::*;
#(
    parameter int DEV_NUM  = 0,
    parameter int NUM_BANK = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [7:0]            idx,
    input  logic [7:0]            ldsel,
    input  logic [7:0]            wdata,
    output logic [NUM_BANK*8-1:0] regs_o,
    output logic                  act_o
);
    logic mine;
    assign mine = wr_en && (int'(ldsel) == DEV_NUM);

    for (genvar r = 0; r < NUM_BANK; r++) begin : g_reg
        localparam logic [7:0] MY_IDX = IDX_BANK_BASE + 8'(r);
        logic [7:0] reg_q;
        always_ff @(posedge clk) begin
            if (rst)                        reg_q <= 8'h00;
            else if (mine && idx == MY_IDX) reg_q <= wdata;
        end
        assign regs_o[r*8 +: 8] = reg_q;
    end

    assign act_o = regs_o[0];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] CHIP_ID   = 8'hA0,
    parameter int         NUM_LDEV  = 4,
    parameter int         NUM_BANK  = 4,
    parameter logic [7:0] GMUX_BASE = 8'h28,
    parameter int         GMUX_NUM  = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           io_addr,
    input  logic                           io_wr,
    input  logic                           io_rd,
    input  logic [7:0]                     io_wdata,
    output logic [7:0]                     io_rdata,
    output logic [GMUX_NUM*8-1:0]          glob_mux_o,
    output logic [NUM_LDEV*NUM_BANK*8-1:0] ldev_cfg_o,
    output logic [NUM_LDEV-1:0]            ldev_act_o
);
    localparam int BANK_BITS = NUM_BANK * 8;

    io_op_t     op;
    logic       unlocked;
    logic       load_idx;
    logic       dat_wr_en;
    logic [7:0] idx_q;
    logic [7:0] ldsel;

    assign op.idx_wr = io_wr && !io_addr;
    assign op.dat_wr = io_wr &&  io_addr;
    assign op.data   = io_wdata;

    sio_key_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .unlocked (unlocked),
        .load_idx (load_idx)
    );

    always_ff @(posedge clk) begin
        if (rst)           idx_q <= 8'h00;
        else if (load_idx) idx_q <= io_wdata;
    end

    assign dat_wr_en = op.dat_wr && unlocked;

    sio_cfg_global #(
        .GMUX_BASE (GMUX_BASE),
        .GMUX_NUM  (GMUX_NUM)
    ) u_glob (
        .clk   (clk),
        .rst   (rst),
        .wr_en (dat_wr_en),
        .idx   (idx_q),
        .wdata (io_wdata),
        .ldsel (ldsel),
        .mux_o (glob_mux_o)
    );

    for (genvar d = 0; d < NUM_LDEV; d++) begin : g_dev
        sio_ldev_bank #(
            .DEV_NUM  (d),
            .NUM_BANK (NUM_BANK)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (dat_wr_en),
            .idx    (idx_q),
            .ldsel  (ldsel),
            .wdata  (io_wdata),
            .regs_o (ldev_cfg_o[d*BANK_BITS +: BANK_BITS]),
            .act_o  (ldev_act_o[d])
        );
    end

    always_comb begin
        io_rdata = RD_EMPTY;
        if (io_rd) begin
            if (!unlocked) begin
                io_rdata = RD_LOCKED;
            end else if (!io_addr) begin
                io_rdata = idx_q;
            end else if (idx_q == IDX_LDSEL) begin
                io_rdata = ldsel;
            end else if (idx_q == IDX_CHIPID) begin
                io_rdata = CHIP_ID;
            end else if (in_window(idx_q, GMUX_BASE, GMUX_NUM)) begin
                io_rdata = glob_mux_o[win_off(idx_q, GMUX_BASE)*8 +: 8];
            end else if (in_window(idx_q, IDX_BANK_BASE, NUM_BANK) &&
                         int'(ldsel) < NUM_LDEV) begin
                io_rdata = ldev_cfg_o[(int'(ldsel)*NUM_BANK +
                                       win_off(idx_q, IDX_BANK_BASE))*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter logic [7:0] CHIP_ID  = 8'hA0,
    parameter int         NUM_LDEV = 4,
    parameter int         NUM_BANK = 4,
    parameter int         GMUX_NUM = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           io_addr,
    input logic                           io_wr,
    input logic                           io_rd,
    input logic [7:0]                     io_wdata,
    input logic [7:0]                     io_rdata,
    input logic                           unlocked,
    input logic [7:0]                     idx_q,
    input logic [GMUX_NUM*8-1:0]          glob_mux_o,
    input logic [NUM_LDEV*NUM_BANK*8-1:0] ldev_cfg_o
);
    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(io_wr && !io_addr && io_wdata == 8'h87)); // R2

    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !unlocked) |-> (io_rdata == 8'hFF)); // R4

    AST_LOCKED_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && io_wr && io_addr) |=> ($stable(ldev_cfg_o) && $stable(glob_mux_o))); // R4

    AST_EXIT_KEY_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (unlocked && io_wr && !io_addr && io_wdata == 8'hAA) |=> (!unlocked && $stable(idx_q))); // R5

    AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
        (unlocked && io_rd && io_addr && idx_q == 8'h20) |-> (io_rdata == CHIP_ID)); // R8

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == 8'h00)); // R12
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .CHIP_ID  (CHIP_ID),
    .NUM_LDEV (NUM_LDEV),
    .NUM_BANK (NUM_BANK),
    .GMUX_NUM (GMUX_NUM)
) u_chk (.*);

// File: tb/sio_cfg_port_tb.sv
`timescale 1ns/1ps
module sio_cfg_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_addr = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [31:0] glob_mux_o;
    logic [127:0] ldev_cfg_o;
    logic [3:0]  ldev_act_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sio_cfg_port u_dut (
        .clk        (clk),
        .rst        (rst),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .glob_mux_o (glob_mux_o),
        .ldev_cfg_o (ldev_cfg_o),
        .ldev_act_o (ldev_act_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
        io_write(1'b0, idx);
        io_write(1'b1, d);
    endtask

    task automatic cfg_read(input logic [7:0] idx, output logic [7:0] d);
        io_write(1'b0, idx);
        io_read(1'b1, d);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        io_read(1'b1, v);       check("R1 data read locked", v, 8'hFF);
        io_read(1'b0, v);       check("R1 index read locked", v, 8'hFF);
        check("R1 act bits", ldev_act_o, 4'h0);
        check("R1 mux bytes", glob_mux_o, 32'h0);
        check("R1 bank regs", (ldev_cfg_o == '0), 1'b1);
        #1 check("R12 idle rdata", io_rdata, 8'h00);
    endtask

    task automatic t_key;
        logic [7:0] v;
        io_write(1'b0, 8'h87);
        io_read(1'b1, v);       check("R2 one key byte stays locked", v, 8'hFF);
        io_write(1'b0, 8'h87);
        io_read(1'b0, v);       check("R2 open after two keys, R6 index=0", v, 8'h00);
    endtask

    task automatic t_locked_write;
        logic [7:0] v;
        cfg_write(8'h31, 8'h3C);
        io_write(1'b0, 8'hAA);
        io_read(1'b1, v);       check("R5 exit key locks", v, 8'hFF);
        io_read(1'b0, v);       check("R6 index read locked", v, 8'hFF);
        io_write(1'b1, 8'hEE);
        check("R4 locked write no effect", ldev_cfg_o[15:8], 8'h3C);
        io_write(1'b0, 8'h87);
        io_write(1'b0, 8'h87);
        io_read(1'b0, v);       check("R5 index kept across exit", v, 8'h31);
        io_read(1'b1, v);       check("R4 register intact after lock", v, 8'h3C);
    endtask

    task automatic t_restart;
        logic [7:0] v;
        io_write(1'b0, 8'hAA);
        io_write(1'b0, 8'h87);
        io_write(1'b0, 8'h55);
        io_write(1'b0, 8'h87);
        io_read(1'b1, v);       check("R3 broken key stays locked", v, 8'hFF);
        io_write(1'b0, 8'h87);
        cfg_read(8'h20, v);     check("R3 restarted key opens / R8 id", v, 8'hA0);
    endtask

    task automatic t_devices;
        logic [7:0] v;
        cfg_write(8'h07, 8'h02);
        cfg_write(8'h30, 8'h01);
        check("R9 activation bit of device 2", ldev_act_o, 4'b0100);
        cfg_write(8'h31, 8'h77);
        cfg_read(8'h07, v);     check("R7 selector readback", v, 8'h02);
        cfg_write(8'h07, 8'h00);
        cfg_read(8'h31, v);     check("R7 device 0 copy", v, 8'h3C);
        cfg_write(8'h07, 8'h02);
        cfg_read(8'h31, v);     check("R7 device 2 copy", v, 8'h77);
        check("R7 device 2 output", ldev_cfg_o[2*32+8 +: 8], 8'h77);
    endtask

    task automatic t_global;
        logic [7:0] v;
        cfg_write(8'h07, 8'h00);
        cfg_write(8'h29, 8'hC3);
        cfg_write(8'h07, 8'h03);
        cfg_read(8'h29, v);     check("R10 shared mux byte", v, 8'hC3);
        check("R10 mux output", glob_mux_o[15:8], 8'hC3);
    endtask

    task automatic t_id;
        logic [7:0] v;
        cfg_write(8'h20, 8'h11);
        cfg_read(8'h20, v);     check("R8 id read-only", v, 8'hA0);
    endtask

    task automatic t_range;
        logic [7:0] v;
        cfg_write(8'h07, 8'h05);
        cfg_write(8'h30, 8'h01);
        check("R11 out-of-range select no activation", ldev_act_o, 4'b0100);
        cfg_read(8'h30, v);     check("R11 out-of-range bank read", v, 8'h00);
        cfg_write(8'h25, 8'h99);
        cfg_read(8'h25, v);     check("R11 unimplemented index", v, 8'h00);
        #1 check("R12 rdata without strobe", io_rdata, 8'h00);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_key();
        t_locked_write();
        t_restart();
        t_devices();
        t_global();
        t_id();
        t_range();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule